// File: doc/BRIEF.md
# Grouped Byte Store with Single-Error Correction

This block sits between a byte-addressed controller and a storage array that holds data in aligned four-byte groups. Each stored word is 38 bits wide: 32 data bits plus 6 Hamming check bits. A group is the four bytes at byte addresses 4N, 4N+1, 4N+2 and 4N+3, and it is stored as one word at group index N.

On a read, the block fetches the group word, repairs any single flipped bit and returns the requested byte. It raises a one-cycle flag when a repair was needed.

On a write, the block performs a read-modify-write. It fetches the group and repairs it. It then replaces the bytes selected by a four-bit lane mask, recomputes the check bits and writes the whole group back. Every write therefore rewrites all four bytes of the group. A per-group write-cycle counter records this wear and reports it with each completed write.

The correction is transparent to the controller: apart from the repair flag, the returned data and the timing are the same whether or not an error was present.

Top module: `gecc_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `rsp_corrected`, `wr_done`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: For a read request accepted at a clock edge, `rsp_valid` is high for exactly one cycle, starting after the second following edge. `rsp_rdata` then holds the byte in lane `req_addr[1:0]` (lane j is data bits 8j+7..8j) of group `req_addr >> 2`. `req_ready` is 0 while a request is in progress.
- R3: A single flipped bit in any of the 32 data bits of the stored word is repaired on read, and `rsp_corrected` is 1 in the response cycle.
- R4: A single flipped check bit (word bits 37..32) leaves the returned data unchanged and still sets `rsp_corrected`.
- R5: A read of an error-free word returns `rsp_corrected` = 0.
- R6: A write reads group `req_addr >> 2` and then issues exactly one `mem_wr_en` pulse to the same `mem_addr`. Lanes whose `req_be[j]` is 1 take `req_wdata[8j+7:8j]`; all other lanes keep the stored data.
- R7: The written word is laid out as {check[5:0], data[31:0]}. Hamming positions 1..38 are used, and the powers of two are reserved for check bits. Data bit i takes the i-th remaining position in ascending order. Check bit k is the XOR of the data bits whose position has bit k set.
- R8: Lanes that a write does not replace are written back in their repaired form when the stored word had a single-bit error.
- R9: A write with `req_be` = 0 still rewrites the group with its unchanged (repaired) data and counts as a write cycle.
- R10: `wr_done` pulses together with `mem_wr_en`, and `wr_count` gives the number of writes to that group since reset. Writes to any byte of a group count toward the same total, and each group's total is independent of the others.
- R11: A group's write count saturates at 2^CNT_W − 1 and never wraps.
- R12: A read never asserts `mem_wr_en` and does not change any write count. `mem_rd_en` and `mem_wr_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is accepted at the edge where both are 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Lane mask for writes |
| req_wdata | input | 32 | Write data, one byte per lane |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 8 | Returned byte |
| rsp_corrected | output | 1 | The read needed a single-bit repair |
| wr_done | output | 1 | Group write issued (one cycle) |
| wr_count | output | CNT_W | Write count of the group just written |
| mem_rd_en | output | 1 | Storage read strobe; data is returned one cycle later |
| mem_wr_en | output | 1 | Storage write strobe |
| mem_addr | output | ADDR_W-2 | Group index |
| mem_wdata | output | 38 | Encoded word to store |
| mem_rdata | input | 38 | Encoded word returned by the storage |

## Verification
The bench builds the block with ADDR_W = 6, which gives 16 groups. It uses a small storage model into which the bench can flip single bits at will, so errors can be injected at data bit 0, at a middle bit, at bit 31 and at check bits. CNT_W = 3 brings the saturation point of the wear counter within eight writes, so the counter can be driven past its limit and the absence of wrap observed. Several groups are written in turn to show that their totals stay apart.

// File: rtl/gecc_pkg.sv
package gecc_pkg;

    localparam int GECC_DW = 32;
    localparam int GECC_KW = 6;
    localparam int GECC_CW = GECC_DW + GECC_KW;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_DEC  = 2'd2
    } gecc_st_e;

    // Hamming position (1..38) held by data bit idx; powers of two are check slots
    function automatic int gecc_dpos(input int idx);
        int n;
        int p;
        n = 0;
        p = 0;
        for (int q = 1; q <= GECC_CW; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (n == idx) p = q;
                n++;
            end
        end
        return p;
    endfunction

    function automatic logic [GECC_KW-1:0] gecc_check(input logic [GECC_DW-1:0] d);
        logic [GECC_KW-1:0] c;
        int p;
        c = '0;
        for (int i = 0; i < GECC_DW; i++) begin
            p = gecc_dpos(i);
            if (d[i]) c = c ^ p[GECC_KW-1:0];
        end
        return c;
    endfunction

endpackage

// File: rtl/gecc_encode.sv
module gecc_encode
    import gecc_pkg::*;
(
    input  logic [GECC_DW-1:0] data_i,
    output logic [GECC_CW-1:0] cw_o
);

    always_comb begin
        cw_o = {gecc_check(data_i), data_i};
    end

endmodule

// File: rtl/gecc_decode.sv
module gecc_decode
    import gecc_pkg::*;
(
    input  logic [GECC_CW-1:0] cw_i,
    output logic [GECC_DW-1:0] data_o,
    output logic               err_o
);

    logic [GECC_KW-1:0] syn;

    always_comb begin
        syn    = gecc_check(cw_i[GECC_DW-1:0]) ^ cw_i[GECC_CW-1:GECC_DW];
        data_o = cw_i[GECC_DW-1:0];
        for (int i = 0; i < GECC_DW; i++) begin
            if (syn == GECC_KW'(gecc_dpos(i))) data_o[i] = ~cw_i[i];
        end
        err_o = |syn;
    end

endmodule

// File: rtl/gecc_wear.sv
module gecc_wear #(
    parameter int NGRP  = 64,
    parameter int GRP_W = 6,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump_i,
    input  logic [GRP_W-1:0] grp_i,
    output logic [CNT_W-1:0] next_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [NGRP];
    logic [CNT_W-1:0] cur;

    always_comb begin
        cur    = cnt_q[grp_i];
        next_o = (cur == CNT_MAX) ? cur : cur + 1'b1;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_cnt
        logic [CNT_W-1:0] cnt_d;

        always_comb begin
            cnt_d = cnt_q[g];
            if (bump_i && (grp_i == GRP_W'(g))) cnt_d = next_o;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q[g] <= '0;
            else        cnt_q[g] <= cnt_d;
        end

        AST_WEAR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[g] == CNT_MAX) |=> (cnt_q[g] == CNT_MAX)); // R11
        AST_WEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(cnt_q[g]) |-> (cnt_q[g] == CNT_W'($past(cnt_q[g]) + 1'b1))); // R10
    end

endmodule

// File: rtl/gecc_unit.sv
module gecc_unit
    import gecc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [3:0]          req_be,
    input  logic [GECC_DW-1:0]  req_wdata,
    output logic                rsp_valid,
    output logic [7:0]          rsp_rdata,
    output logic                rsp_corrected,
    output logic                wr_done,
    output logic [CNT_W-1:0]    wr_count,
    output logic                mem_rd_en,
    output logic                mem_wr_en,
    output logic [ADDR_W-3:0]   mem_addr,
    output logic [GECC_CW-1:0]  mem_wdata,
    input  logic [GECC_CW-1:0]  mem_rdata
);

    localparam int GRP_W = ADDR_W - 2;
    localparam int NGRP  = 1 << GRP_W;

    typedef struct packed {
        gecc_st_e           st;
        logic               wr;
        logic [1:0]         lane;
        logic [3:0]         be;
        logic [GECC_DW-1:0] wdata;
        logic [GRP_W-1:0]   grp;
        logic               rd_en;
        logic               wr_en;
        logic [GECC_CW-1:0] cw;
        logic               rsp_v;
        logic [7:0]         rsp_d;
        logic               corr;
        logic               done;
        logic [CNT_W-1:0]   cnt;
    } regs_t;

    regs_t r_d, r_q;

    logic [GECC_DW-1:0] fix_data;
    logic               fix_err;
    logic [GECC_DW-1:0] merged;
    logic [GECC_CW-1:0] enc_cw;
    logic [CNT_W-1:0]   wear_next;
    logic               wear_bump;

    gecc_decode i_dec (
        .cw_i   (mem_rdata),
        .data_o (fix_data),
        .err_o  (fix_err)
    );

    for (genvar j = 0; j < 4; j++) begin : g_lane
        assign merged[8*j +: 8] = r_q.be[j] ? r_q.wdata[8*j +: 8] : fix_data[8*j +: 8];
    end

    gecc_encode i_enc (
        .data_i (merged),
        .cw_o   (enc_cw)
    );

    assign wear_bump = (r_q.st == ST_DEC) && r_q.wr;

    gecc_wear #(
        .NGRP  (NGRP),
        .GRP_W (GRP_W),
        .CNT_W (CNT_W)
    ) i_wear (
        .clk    (clk),
        .rst_n  (rst_n),
        .bump_i (wear_bump),
        .grp_i  (r_q.grp),
        .next_o (wear_next)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rd_en = 1'b0;
        r_d.wr_en = 1'b0;
        r_d.rsp_v = 1'b0;
        r_d.corr  = 1'b0;
        r_d.done  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_READ;
                    r_d.wr    = req_write;
                    r_d.lane  = req_addr[1:0];
                    r_d.be    = req_be;
                    r_d.wdata = req_wdata;
                    r_d.grp   = req_addr[ADDR_W-1:2];
                    r_d.rd_en = 1'b1;
                end
            end
            ST_READ: r_d.st = ST_DEC;
            ST_DEC: begin
                r_d.st = ST_IDLE;
                if (r_q.wr) begin
                    r_d.cw    = enc_cw;
                    r_d.wr_en = 1'b1;
                    r_d.done  = 1'b1;
                    r_d.cnt   = wear_next;
                end else begin
                    r_d.rsp_v = 1'b1;
                    r_d.rsp_d = fix_data[8*r_q.lane +: 8];
                    r_d.corr  = fix_err;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign rsp_valid     = r_q.rsp_v;
    assign rsp_rdata     = r_q.rsp_d;
    assign rsp_corrected = r_q.corr;
    assign wr_done       = r_q.done;
    assign wr_count      = r_q.cnt;
    assign mem_rd_en     = r_q.rd_en;
    assign mem_wr_en     = r_q.wr_en;
    assign mem_addr      = r_q.grp;
    assign mem_wdata     = r_q.cw;

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R2
    AST_CORR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_corrected |-> rsp_valid); // R5
    AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en, 2) && (mem_addr == $past(mem_addr, 2)))); // R6
    AST_DONE_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> mem_wr_en); // R10
    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R12
    AST_ONE_BIT_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DEC) |-> ($countones(fix_data ^ mem_rdata[GECC_DW-1:0]) <= 1)); // R3

endmodule

// File: tb/test_gecc_unit.sv
`timescale 1ns/1ps
module test_gecc_unit;

    localparam int AW = 6;
    localparam int CW = 3;
    localparam int NG = 1 << (AW - 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_be = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [7:0]    rsp_rdata;
    logic          rsp_corrected;
    logic          wr_done;
    logic [CW-1:0] wr_count;
    logic          mem_rd_en;
    logic          mem_wr_en;
    logic [AW-3:0] mem_addr;
    logic [37:0]   mem_wdata;
    logic [37:0]   mem_rdata;

    logic [37:0]   store [NG];
    int            n_run = 0;
    int            n_fail = 0;
    bit            finished = 0;

    // samples taken at the response negedge
    int            lat;
    logic [7:0]    s_rdata;
    logic          s_corr;
    logic          s_wr_seen;
    logic [37:0]   s_wdata;
    logic [AW-3:0] s_waddr;
    logic [CW-1:0] s_cnt;
    logic          s_ready_busy;

    always #4 clk = ~clk;

    gecc_unit #(.ADDR_W(AW), .CNT_W(CW)) i_gecc_unit (
        .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_be,
        .req_wdata, .rsp_valid, .rsp_rdata, .rsp_corrected, .wr_done, .wr_count,
        .mem_rd_en, .mem_wr_en, .mem_addr, .mem_wdata, .mem_rdata
    );

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= store[mem_addr];
        if (mem_wr_en) store[mem_addr] <= mem_wdata;
    end

    function automatic logic [37:0] code_of(input logic [31:0] d);
        logic [5:0] c = '0;
        int di = 0;
        for (int pos = 1; pos <= 38; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (d[di]) c = c ^ 6'(pos);
                di++;
            end
        end
        return {c, d};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0; s_wr_seen = 1'b0; s_ready_busy = 1'b0;
        do begin
            if (req_ready) s_ready_busy = 1'b1;
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (mem_wr_en) s_wr_seen = 1'b1;
        end while (!rsp_valid && !wr_done && lat < 20);
        s_rdata = rsp_rdata; s_corr = rsp_corrected;
        s_wdata = mem_wdata; s_waddr = mem_addr; s_cnt = wr_count;
        @(negedge clk);
        chk(!rsp_valid && !wr_done, "R2 pulse length", {62'd0, rsp_valid, wr_done}, 64'd0);
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk({rsp_valid, rsp_corrected, wr_done, mem_rd_en, mem_wr_en} == 5'd0, "R1 outputs",
            {rsp_valid, rsp_corrected, wr_done, mem_rd_en, mem_wr_en}, 0);
    endtask

    task automatic t_clean_read;
        logic [31:0] d = 32'hA1B2C3D4;
        store[3] = code_of(d);
        for (int ln = 0; ln < 4; ln++) begin
            issue(1'b0, AW'(12 + ln), 4'h0, 32'h0);
            chk(lat == 2, "R2 latency", lat, 2);
            chk(!s_ready_busy, "R2 ready while busy", s_ready_busy, 0);
            chk(s_rdata == d[8*ln +: 8], "R2 byte lane", s_rdata, d[8*ln +: 8]);
            chk(!s_corr, "R5 clean flag", s_corr, 0);
            chk(!s_wr_seen, "R12 read no write", s_wr_seen, 0);
        end
    endtask

    task automatic t_data_error;
        logic [31:0] d = 32'h5EC0_1D7A;
        int bits [3] = '{0, 17, 31};
        foreach (bits[k]) begin
            store[5] = code_of(d) ^ (38'd1 << bits[k]);
            issue(1'b0, AW'(20 + bits[k] / 8), 4'h0, 32'h0);
            chk(s_rdata == d[8*(bits[k]/8) +: 8], "R3 repaired byte", s_rdata, d[8*(bits[k]/8) +: 8]);
            chk(s_corr, "R3 flag", s_corr, 1);
        end
    endtask

    task automatic t_check_error;
        logic [31:0] d = 32'h0BAD_F00D;
        for (int k = 0; k < 6; k += 5) begin
            store[6] = code_of(d) ^ (38'd1 << (32 + k));
            issue(1'b0, AW'(24 + 1), 4'h0, 32'h0);
            chk(s_rdata == d[15:8], "R4 data kept", s_rdata, d[15:8]);
            chk(s_corr, "R4 flag", s_corr, 1);
        end
    endtask

    task automatic t_write_merge;
        logic [31:0] d = 32'h11223344;
        logic [31:0] nw = 32'hAABBCCDD;
        logic [31:0] ex = {d[31:24], nw[23:16], d[15:8], nw[7:0]};
        store[2] = code_of(d);
        issue(1'b1, AW'(9), 4'b0101, nw);
        chk(lat == 2 && s_wr_seen, "R6 write issued", lat, 2);
        chk(s_waddr == 2, "R6 group addr", s_waddr, 2);
        chk(s_wdata == code_of(ex), "R7 encoded merge", s_wdata, code_of(ex));
        chk(s_cnt == 1, "R10 first count", s_cnt, 1);
    endtask

    task automatic t_write_repairs;
        logic [31:0] d = 32'hCAFE_4321;
        store[7] = code_of(d) ^ 38'h8;
        issue(1'b1, AW'(28), 4'b1000, 32'h9900_0000);
        chk(s_wdata == code_of({8'h99, d[23:0]}), "R8 repaired lanes", s_wdata, code_of({8'h99, d[23:0]}));
        chk(store[7] == code_of({8'h99, d[23:0]}), "R8 stored word", store[7], code_of({8'h99, d[23:0]}));
    endtask

    task automatic t_write_noop;
        logic [37:0] prev = store[2];
        issue(1'b1, AW'(10), 4'b0000, 32'hFFFF_FFFF);
        chk(s_wr_seen && s_wdata == prev, "R9 unchanged rewrite", s_wdata, prev);
        chk(s_cnt == 2, "R9 counted", s_cnt, 2);
    endtask

    task automatic t_wear_groups;
        issue(1'b1, AW'(39), 4'b0001, 32'h5);
        chk(s_cnt == 1, "R10 other group", s_cnt, 1);
        issue(1'b0, AW'(8), 4'h0, 32'h0);
        issue(1'b0, AW'(11), 4'h0, 32'h0);
        issue(1'b1, AW'(11), 4'b0010, 32'h0000_7700);
        chk(s_cnt == 3, "R12 reads not counted", s_cnt, 3);
    endtask

    task automatic t_saturate;
        store[11] = code_of(32'h0);
        for (int w = 1; w <= 9; w++) begin
            issue(1'b1, AW'(44 + (w % 4)), 4'b0001, 32'(w));
            chk(s_cnt == CW'((w > 7) ? 7 : w), "R11 saturating count", s_cnt, (w > 7) ? 7 : w);
        end
    endtask

    initial begin
        for (int g = 0; g < NG; g++) store[g] = code_of(32'h0);
        mem_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean_read();
        t_data_error();
        t_check_error();
        t_write_merge();
        t_write_repairs();
        t_write_noop();
        t_wear_groups();
        t_saturate();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule